// File: doc/BRIEF.md
# Programmable Low-Power Sequence Engine

This block runs short byte-coded programs that step a set of power control lines when a core asks to go to sleep. Software fills a 32-word program memory over a simple register bus and writes a control register holding an enable bit and a 7-bit start pointer. The start pointer is a byte index into the program memory, and each 32-bit word packs four byte commands.

When `sleep_req` is seen with the enable bit set, the engine leaves ST_IDLE for ST_FETCH and reads one byte per cycle from the start pointer onward. A byte with its top bit clear is driven onto `ctl_out`. A byte with its top bit set moves to ST_WAIT and pauses for the count held in its low 7 bits. Fetching the end code 0x0F, or reaching byte index 127, moves to ST_DONE. ST_DONE raises `done` for one cycle and clears the start pointer field, then returns to ST_IDLE.

The transitions are:
- IDLE_TO_FETCH: request with enable set.
- FETCH_TO_FETCH: control byte.
- FETCH_TO_WAIT: wait byte.
- WAIT_TO_FETCH: count exhausted.
- FETCH_TO_DONE: end code or index 127.
- DONE_TO_IDLE: always.

Top module: `lpseq_engine`

## Requirements
- R1: After reset, `ctl_out`, `busy` and `done` are 0, the control register reads 0, and every program word reads 0x0F0F0F0F.
- R2: The control register is at byte offset 0x20, and program word i is at 0x80+4*i for i in 0..31; each reads back what was last written. Reads of any other offset, including unaligned ones such as 0x81, return 0. A write to an unmapped offset changes no register.
- R3: Control bit 0 is the enable bit and bits 10:4 are the start byte index. All 32 control bits read back as written.
- R4: `sleep_req` starts a run only when the enable bit is 1. With the enable bit at 0, `busy` and `done` stay 0 and `ctl_out` holds its value.
- R5: Byte index b is taken from word b/4, bits 8*(b%4)+7 down to 8*(b%4), so the first command of a word is in bits 7:0.
- R6: A byte with bit 7 = 0 that is not 0x0F is copied (bits 6:0) to `ctl_out`. If the request edge is cycle 0, the k-th fetch happens at edge k, and the next byte is fetched one cycle later.
- R7: A byte with bit 7 = 1 and count N (bits 6:0) fetched at edge t causes the next byte to be fetched at edge t+N+2, with `ctl_out` held in between.
- R8: Fetching 0x0F at edge t ends the run: `done` is 1 in the cycle after edge t only, and `busy` is 0 from then on.
- R9: An unprogrammed engine ends at once: `done` rises after edge 1 and `ctl_out` is unchanged.
- R10: A start index of 127, or a run reaching index 127, ends at that fetch without applying the byte stored there.
- R11: At the end of a run the start index field becomes 0 while every other control bit keeps its value.
- R12: A control register write in the same cycle as the end-of-run clear takes precedence, and the written value is kept in full.
- R13: `busy` is 1 from the cycle after the request edge until the end fetch, and `sleep_req` has no effect while a run or its `done` cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sleep_req | input | 1 | Low-power request |
| ctl_out | output | 7 | Power control lines |
| busy | output | 1 | Program running (fetch or wait) |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two actions can fall on the same edge:
- the hardware clear of the start index when the end code is fetched;
- a software write to the control register.

The bench computes the edge at which the end code will be fetched and drives a control write into exactly that edge. It then reads the register back and expects the full written value, including a non-zero start index. Around this directed case, random programs with random start points, commands and waits are checked cycle by cycle against a bench model of the fetch timing.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    localparam logic [7:0] SEQ_END_CODE = 8'h0F;
endpackage

// File: rtl/lpseq_progmem.sv
module lpseq_progmem #(
    parameter int unsigned WORDS    = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CMD_W    = 8,
    parameter logic [7:0]  END_CODE = 8'h0F,
    localparam int unsigned LANES  = DATA_W / CMD_W,
    localparam int unsigned IDX_W  = $clog2(WORDS),
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned PTR_W  = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PTR_W-1:0]  fetch_ptr,
    output logic [CMD_W-1:0]  fetch_byte
);
    localparam logic [DATA_W-1:0] FILL = {LANES{END_CODE[CMD_W-1:0]}};

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] fetch_word;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] WI = IDX_W'(w);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[w] <= FILL;
            else if (wr_en && wr_idx == WI)
                mem_q[w] <= wr_data;
        end
    end

    assign rd_data    = mem_q[rd_idx];
    assign fetch_word = mem_q[fetch_ptr[PTR_W-1:LANE_W]];
    assign fetch_byte = fetch_word[fetch_ptr[LANE_W-1:0]*CMD_W +: CMD_W];
endmodule

// File: rtl/lpseq_ctrlreg.sv
module lpseq_ctrlreg #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PTR_LSB = 4,
    parameter int unsigned PTR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_ptr,
    output logic [DATA_W-1:0] ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
        else if (clr_ptr)
            ctrl_q[PTR_LSB +: PTR_W] <= '0;
    end
endmodule

// File: rtl/lpseq_fsm.sv
module lpseq_fsm
    import lpseq_pkg::*;
#(
    parameter int unsigned PTR_W    = 7,
    parameter int unsigned CMD_W    = 8,
    parameter logic [7:0]  END_CODE = SEQ_END_CODE,
    localparam int unsigned CTL_W = CMD_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic [PTR_W-1:0] start_ptr,
    output logic [PTR_W-1:0] fetch_ptr,
    input  logic [CMD_W-1:0] fetch_byte,
    output logic [CTL_W-1:0] ctl_out,
    output logic             busy,
    output logic             done,
    output logic             clr_ptr
);
    localparam logic [PTR_W-1:0] LAST_PTR = '1;

    seq_state_t       state_q, state_d;
    logic [PTR_W-1:0] pc_q;
    logic [CTL_W-1:0] cnt_q;
    logic [CTL_W-1:0] ctl_q;
    logic             is_end;
    logic             is_wait;

    assign is_end  = (pc_q == LAST_PTR) || (fetch_byte == END_CODE[CMD_W-1:0]);
    assign is_wait = fetch_byte[CMD_W-1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_FETCH;
            ST_FETCH: begin
                if (is_end)       state_d = ST_DONE;
                else if (is_wait) state_d = ST_WAIT;
            end
            ST_WAIT:  if (cnt_q == '0) state_d = ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_ok)
                pc_q <= start_ptr;
            else if (state_q == ST_FETCH && !is_end) begin
                pc_q <= pc_q + 1'b1;
                if (is_wait)
                    cnt_q <= fetch_byte[CTL_W-1:0];
            end else if (state_q == ST_WAIT && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (state_q == ST_FETCH && !is_end && !is_wait)
            ctl_q <= fetch_byte[CTL_W-1:0];
    end

    assign fetch_ptr = pc_q;
    assign ctl_out   = ctl_q;
    assign busy      = (state_q == ST_FETCH) || (state_q == ST_WAIT);
    assign done      = (state_q == ST_DONE);
    assign clr_ptr   = (state_q == ST_FETCH) && is_end;
endmodule

// File: rtl/lpseq_engine.sv
module lpseq_engine #(
    parameter int unsigned PROG_WORDS = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CMD_W      = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PTR_LSB    = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h20,
    parameter logic [ADDR_W-1:0] PROG_OFS = 'h80,
    localparam int unsigned CTL_W = CMD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_req,
    output logic [CTL_W-1:0]  ctl_out,
    output logic              busy,
    output logic              done
);
    localparam int unsigned IDX_W   = $clog2(PROG_WORDS);
    localparam int unsigned PTR_W   = IDX_W + $clog2(DATA_W / CMD_W);
    localparam int unsigned BSEL_W  = $clog2(DATA_W / 8);
    localparam int unsigned BLK_LSB = IDX_W + BSEL_W;

    logic              ctrl_hit, prog_hit;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] ctrl_q, prog_rd;
    logic [PTR_W-1:0]  fetch_ptr;
    logic [CMD_W-1:0]  fetch_byte;
    logic              clr_ptr;

    assign ctrl_hit = (reg_addr == CTRL_OFS);
    assign prog_hit = (reg_addr[ADDR_W-1:BLK_LSB] == PROG_OFS[ADDR_W-1:BLK_LSB])
                   && (reg_addr[BSEL_W-1:0] == '0);
    assign word_idx = reg_addr[BLK_LSB-1:BSEL_W];

    always_comb begin
        if (ctrl_hit)      reg_rdata = ctrl_q;
        else if (prog_hit) reg_rdata = prog_rd;
        else               reg_rdata = '0;
    end

    lpseq_ctrlreg #(.DATA_W(DATA_W), .PTR_LSB(PTR_LSB), .PTR_W(PTR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we && ctrl_hit), .wr_data(reg_wdata),
        .clr_ptr(clr_ptr), .ctrl_q(ctrl_q)
    );

    lpseq_progmem #(.WORDS(PROG_WORDS), .DATA_W(DATA_W), .CMD_W(CMD_W)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we && prog_hit), .wr_idx(word_idx), .wr_data(reg_wdata),
        .rd_idx(word_idx), .rd_data(prog_rd),
        .fetch_ptr(fetch_ptr), .fetch_byte(fetch_byte)
    );

    lpseq_fsm #(.PTR_W(PTR_W), .CMD_W(CMD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .start_ok(sleep_req && ctrl_q[0]),
        .start_ptr(ctrl_q[PTR_LSB +: PTR_W]),
        .fetch_ptr(fetch_ptr), .fetch_byte(fetch_byte),
        .ctl_out(ctl_out), .busy(busy), .done(done), .clr_ptr(clr_ptr)
    );
endmodule

// File: rtl/lpseq_chk.sv
module lpseq_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CTL_W   = 7,
    parameter int unsigned PTR_LSB = 4,
    parameter int unsigned PTR_W   = 7,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CTL_W-1:0]  ctl_out,
    input logic              busy,
    input logic              done
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R13
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sleep_req && ctrl_q[0]));
    // R6
    ctl_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_out) |-> $past(busy));
    // R11
    ptr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctrl_q[PTR_LSB +: PTR_W] == '0) || $past(reg_we && reg_addr == CTRL_OFS));
endmodule

bind lpseq_engine lpseq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_W(CTL_W),
    .PTR_LSB(PTR_LSB), .PTR_W(PTR_W), .CTRL_OFS(CTRL_OFS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .ctrl_q(ctrl_q), .ctl_out(ctl_out),
    .busy(busy), .done(done)
);

// File: tb/lpseq_engine_tb.sv
module lpseq_engine_tb_top;
    localparam int MAXT = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        sleep_req = 1'b0;
    logic [6:0]  ctl_out;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int cyc = 0;

    logic [7:0] mem_m [128];
    int         exp_set [MAXT+1];
    int         exp_done;
    logic [6:0] ctl_m = '0;

    lpseq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .ctl_out(ctl_out), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] word_m(input int w);
        return {mem_m[4*w+3], mem_m[4*w+2], mem_m[4*w+1], mem_m[4*w]};
    endfunction

    task automatic load_all();
        for (int w = 0; w < 32; w++) wr(8'h80 + 8'(4*w), word_m(w));
    endtask

    // Bench model of fetch timing: fetch k happens at edge k after request edge 0
    task automatic model_run(input int start);
        int t = 1;
        int pc = start;
        for (int i = 0; i <= MAXT; i++) exp_set[i] = -1;
        exp_done = -1;
        while (t <= MAXT) begin
            if (pc == 127 || mem_m[pc] == 8'h0F) begin exp_done = t; break; end
            if (mem_m[pc][7] == 1'b0) begin
                exp_set[t] = int'(mem_m[pc][6:0]);
                t = t + 1;
            end else begin
                t = t + int'(mem_m[pc][6:0]) + 2;
            end
            pc = pc + 1;
        end
    endtask

    // Runs with control already written; conc!=0 drives a control write into the end edge
    task automatic run_prog(input int start, input string req, input bit conc,
                            input logic [31:0] cval, input logic [31:0] ctrl_exp);
        int n = 0;
        int trace_bad = 0;
        int cur;
        logic [31:0] d;
        model_run(start);
        cur = int'(ctl_m);
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check(busy == 1'b1 || exp_done == 0, "R13 busy after request", longint'(busy), 1);
        while (n < MAXT) begin
            @(negedge clk);
            n++;
            reg_we = 1'b0;
            sleep_req = 1'b0;
            if (exp_set[n] >= 0) cur = exp_set[n];
            if (ctl_out != 7'(cur)) trace_bad++;
            if (done != (n == exp_done)) trace_bad++;
            if (n == exp_done) break;
            if (n == 1) sleep_req = 1'b1;
            if (conc && n == exp_done - 1) begin
                reg_addr = 8'h20; reg_wdata = cval; reg_we = 1'b1;
            end
        end
        sleep_req = 1'b0;
        check(trace_bad == 0, {req, " trace R6 R7"}, trace_bad, 0);
        check(n == exp_done && done == 1'b1, {req, " R8 done timing"}, n, exp_done);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {req, " R8 R13 single done, no restart"},
              {busy, done}, 0);
        ctl_m = 7'(cur);
        rd(8'h20, d);
        check(d == ctrl_exp, {req, " R11 R12 ctrl after run"}, d, ctrl_exp);
    endtask

    task automatic setup_run(input int start, input logic [31:0] upper, input string req);
        logic [31:0] c;
        c = (upper & 32'hFFFF_F800) | (32'(start) << 4) | 32'h1;
        wr(8'h20, c);
        run_prog(start, req, 1'b0, 32'h0, c & 32'hFFFF_F80F);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(ctl_out == 0 && busy == 0 && done == 0, "R1 outputs", {ctl_out, busy, done}, 0);
        rd(8'h20, d);
        check(d == 0, "R1 ctrl", d, 0);
        begin
            int bad = 0;
            for (int w = 0; w < 32; w++) begin
                rd(8'h80 + 8'(4*w), d);
                if (d != 32'h0F0F0F0F) bad++;
            end
            check(bad == 0, "R1 program fill", bad, 0);
        end

        // R9 unprogrammed run ends at once
        setup_run(0, 32'h0, "R9 empty");

        // R2 R3 register map
        wr(8'h20, 32'hA5A5_5A5A);
        rd(8'h20, d);
        check(d == 32'hA5A5_5A5A, "R3 ctrl readback", d, 32'hA5A5_5A5A);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, d);
        check(d == 0, "R2 unmapped read", d, 0);
        rd(8'h20, d);
        check(d == 32'hA5A5_5A5A, "R2 unmapped write ignored", d, 32'hA5A5_5A5A);
        wr(8'h84, 32'h1234_5678);
        rd(8'h84, d);
        check(d == 32'h1234_5678, "R2 program word", d, 32'h1234_5678);
        rd(8'h85, d);
        check(d == 0, "R2 unaligned read", d, 0);
        wr(8'h84, 32'h0F0F_0F0F);

        // R4 disabled engine ignores request
        mem_m[0] = 8'h2A; mem_m[1] = 8'h0F;
        load_all();
        wr(8'h20, 32'h0000_0000);
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        begin
            int bad = 0;
            repeat (8) begin
                @(negedge clk);
                if (busy || done || ctl_out != ctl_m) bad++;
            end
            check(bad == 0, "R4 disabled no run", bad, 0);
        end

        // R5 R6 byte order: start at byte 1 of word 0
        mem_m[0] = 8'h11; mem_m[1] = 8'h22; mem_m[2] = 8'h33; mem_m[3] = 8'h0F;
        load_all();
        setup_run(1, 32'h0, "R5 lane order start 1");
        check(ctl_out == 7'h33, "R5 final lane", ctl_out, 7'h33);
        setup_run(0, 32'h8000_0000, "R6 start 0");

        // R7 waits of 3 and 0
        mem_m[8] = 8'h05; mem_m[9] = 8'h83; mem_m[10] = 8'h06;
        mem_m[11] = 8'h80; mem_m[12] = 8'h07; mem_m[13] = 8'h0F;
        load_all();
        setup_run(8, 32'h0010_0000, "R7 waits");
        check(ctl_out == 7'h07, "R7 final", ctl_out, 7'h07);

        // R10 start 127 ends without applying byte 127
        mem_m[127] = 8'h11;
        load_all();
        setup_run(127, 32'h0, "R10 start127");
        check(ctl_out == 7'h07, "R10 byte 127 not applied", ctl_out, 7'h07);
        // R10 run reaching 127
        mem_m[125] = 8'h44; mem_m[126] = 8'h55;
        load_all();
        setup_run(125, 32'h0, "R10 reach127");
        check(ctl_out == 7'h55, "R10 reach final", ctl_out, 7'h55);

        // R12 control write coinciding with the end clear
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h0F;
        mem_m[0] = 8'h01; mem_m[1] = 8'h02; mem_m[2] = 8'h03;
        load_all();
        wr(8'h20, 32'h1);
        run_prog(0, "R12 concurrent", 1'b1, 32'h0010_0051, 32'h0010_0051);

        // Random programs
        for (int r = 0; r < 40; r++) begin
            int start = $urandom_range(0, 100);
            int len = $urandom_range(1, 10);
            for (int i = 0; i < 128; i++) mem_m[i] = 8'(($urandom_range(0, 3) == 0) ? 8'h0F : $urandom);
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                if ($urandom_range(0, 3) == 0) b = 8'h80 | 8'($urandom_range(0, 6));
                else begin
                    b = 8'($urandom_range(0, 127));
                    if (b == 8'h0F) b = 8'h10;
                end
                mem_m[start + i] = b;
            end
            mem_m[start + len] = 8'h0F;
            load_all();
            setup_run(start, $urandom, "R6 R7 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule